// File: doc/BRIEF.md
# Energy Pulse Width Limiter

This block drives an energy pulse pin from single-cycle requests raised by a metering engine. Each request becomes one output pulse. The pulse is held at its active level for a limited number of timing ticks and then released. The ticks come from a per-sample strobe. With an interval setting of zero, every strobe is a tick. With an interval setting of N, one tick is produced for every N strobes, and pulse starts are then aligned to those ticks.

A small configuration register sets three things: the maximum-width count W, the tick interval, and the polarity. A pulse stays active for 2W+1 ticks. After it ends, the output stays inactive for one full tick before the next pulse may begin, so back-to-back pulses never merge. A request that arrives while a pulse or its trailing gap is in progress is held in one pending flag. A width setting of all ones switches the block to toggle mode. In toggle mode every request flips the output, which gives a 50% duty cycle when requests are evenly spaced.

Top module: `pulse_width_limiter`

## Requirements
- R1: After reset the configuration is width 255, interval 0 and polarity bit 0. The output is therefore high while idle, and the block is in toggle mode.
- R2: With the polarity bit at 0 the active level is low (0) and the idle level is high (1). With the polarity bit at 1 both levels are swapped.
- R3: In width-limited mode a pulse that starts at clock edge S stays active until the (2W+1)-th tick edge after S. The output shows its idle level from that edge onward.
- R4: With interval 0, every sample strobe is a tick. With interval N > 0, the k-th strobe counted from reset (k = 1, 2, ...) is a tick when k is a multiple of N.
- R5: With interval 0, a request that is idle-accepted at edge R makes the output active right after edge R. With interval > 0, the pulse starts at the first tick edge at or after R.
- R6: When the width field is 255, each request flips the output between idle and active, independent of ticks and of the interval setting.
- R7: A request during a pulse or its gap is held pending. The next pulse then starts at the first tick edge after the previous pulse ended, which leaves exactly one tick period of idle level between the two pulses.
- R8: Only one request can be pending. Further requests that arrive while the flag is already set are dropped.
- R9: The three configuration fields are loaded only on a clock edge with cfg_we_i high. Changes on the configuration inputs without the write enable have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | One-cycle strobe per sample period |
| req_i | input | 1 | One-cycle pulse request |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_max_width_i | input | 8 | Width count W; 255 selects toggle mode |
| cfg_interval_i | input | 8 | Strobes per tick; 0 means one tick per strobe, unpaced |
| cfg_invert_i | input | 1 | Polarity select; 1 makes pulses active-high |
| pulse_o | output | 1 | Pulse output pin |

## Verification
The assertions assume three things about the inputs. Requests and sample strobes are single-cycle. The width setting is not rewritten while a pulse is active, because the bound on the internal width count is stated against the live setting. The bench resets the block before each configuration. It writes the registers while the strobe is held off, so the tick phase is known from the first strobe after the write. It then issues requests only into an idle block or during a running pulse, and it never changes the configuration mid-pulse.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2
  } pwl_state_e;
endpackage

// File: rtl/pwl_cfg_regs.sv
module pwl_cfg_regs #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] max_width_i,
  input  logic [W-1:0] interval_i,
  input  logic         invert_i,
  output logic [W-1:0] max_width_o,
  output logic [W-1:0] interval_o,
  output logic         invert_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_width_o <= '1;
      interval_o  <= '0;
      invert_o    <= 1'b0;
    end else if (we_i) begin
      max_width_o <= max_width_i;
      interval_o  <= interval_i;
      invert_o    <= invert_i;
    end
  end
endmodule

// File: rtl/pwl_tick_gen.sv
module pwl_tick_gen #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic [W-1:0] interval_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  // >= so a shrunk interval cannot strand the counter above the limit
  assign last   = (interval_i == '0) || (cnt_q >= interval_i - W'(1));
  assign tick_o = sample_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (sample_i) cnt_q <= tick_o ? '0 : cnt_q + W'(1);
  end

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni) (tick_o && interval_i != '0) |=> cnt_q == '0); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !sample_i |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/pwl_pulse_fsm.sv
module pwl_pulse_fsm
  import pwl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         req_i,
  input  logic         paced_i,
  input  logic [W-1:0] max_width_i,
  output logic         active_o
);
  localparam int CW = W + 1;

  pwl_state_e    st_q, st_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic          toggle;
  logic [CW-1:0] limit;

  assign toggle = (max_width_i == '1);
  assign limit  = {max_width_i, 1'b0};

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    wcnt_d = wcnt_q;
    if (toggle) begin
      pend_d = 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) st_d = ST_ACT;
        ST_ACT:  if (req_i) st_d = ST_IDLE;
        ST_GAP:  if (tick_i) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if ((req_i || pend_q) && (!paced_i || tick_i)) begin
            st_d   = ST_ACT;
            wcnt_d = '0;
            pend_d = pend_q && req_i;
          end else if (req_i) begin
            pend_d = 1'b1;
          end
        end
        ST_ACT: begin
          if (req_i) pend_d = 1'b1;
          if (tick_i) begin
            if (wcnt_q >= limit) st_d = ST_GAP;
            else                 wcnt_d = wcnt_q + CW'(1);
          end
        end
        ST_GAP: begin
          if (req_i) pend_d = 1'b1;
          if (tick_i) begin
            if (pend_q || req_i) begin
              st_d   = ST_ACT;
              wcnt_d = '0;
              pend_d = pend_q && req_i;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign active_o = (st_q == ST_ACT);

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni) (st_q == ST_ACT && !toggle && !tick_i) |=> st_q == ST_ACT); // R3
  AST_WIDTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) (st_q == ST_ACT && !toggle) |-> wcnt_q <= limit); // R3
  AST_IMMEDIATE_START: assert property (@(posedge clk_i) disable iff (!rst_ni) (!toggle && !paced_i && req_i && st_q == ST_IDLE) |=> st_q == ST_ACT); // R5
  AST_GAP_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni) (st_q == ST_GAP && !tick_i) |=> st_q == ST_GAP); // R7
  AST_PEND_START: assert property (@(posedge clk_i) disable iff (!rst_ni) (st_q == ST_GAP && pend_q && tick_i && !toggle) |=> st_q == ST_ACT); // R7
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni) (toggle && req_i && st_q == ST_ACT) |=> st_q == ST_IDLE); // R6
endmodule

// File: rtl/pulse_width_limiter.sv
module pulse_width_limiter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         req_i,
  input  logic         cfg_we_i,
  input  logic [W-1:0] cfg_max_width_i,
  input  logic [W-1:0] cfg_interval_i,
  input  logic         cfg_invert_i,
  output logic         pulse_o
);
  logic [W-1:0] max_width;
  logic [W-1:0] interval;
  logic         invert;
  logic         tick;
  logic         active;

  pwl_cfg_regs #(.W(W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .max_width_i (cfg_max_width_i),
    .interval_i  (cfg_interval_i),
    .invert_i    (cfg_invert_i),
    .max_width_o (max_width),
    .interval_o  (interval),
    .invert_o    (invert)
  );

  pwl_tick_gen #(.W(W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .interval_i (interval),
    .tick_o     (tick)
  );

  pwl_pulse_fsm #(.W(W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .req_i       (req_i),
    .paced_i     (interval != '0),
    .max_width_i (max_width),
    .active_o    (active)
  );

  // active-low unless inverted
  assign pulse_o = active ? invert : ~invert;

  AST_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !cfg_we_i |=> $stable(invert)); // R9
endmodule

// File: tb/pulse_width_limiter_tb.sv
module pulse_width_limiter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_i = 1'b0;
  logic       req_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_max_width_i = 8'd0;
  logic [7:0] cfg_interval_i = 8'd0;
  logic       cfg_invert_i = 1'b0;
  logic       pulse_o;

  pulse_width_limiter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .req_i(req_i),
    .cfg_we_i(cfg_we_i), .cfg_max_width_i(cfg_max_width_i),
    .cfg_interval_i(cfg_interval_i), .cfg_invert_i(cfg_invert_i), .pulse_o(pulse_o)
  );

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit smp_en = 0;
  int p0 = 0;
  int nv = 0;
  logic act_lvl = 1'b0;
  int nrise, nfall;
  int rise_c[4];
  int fall_c[4];

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // strobe on posedges that are multiples of 4 while enabled
  function automatic bit is_tick(input int p);
    if (p < p0 || ((p - p0) % 4) != 0) return 1'b0;
    return (nv == 0) || ((((p - p0) / 4) + 1) % nv) == 0;
  endfunction

  function automatic int first_ge(input int p);
    for (int q = p; q < p + 5000; q++) if (is_tick(q)) return q;
    return -1;
  endfunction

  function automatic int nth_after(input int p, input int n);
    int c = 0;
    for (int q = p + 1; q < p + 5000; q++) begin
      if (is_tick(q)) begin
        c++;
        if (c == n) return q;
      end
    end
    return -1;
  endfunction

  task automatic step();
    @(negedge clk_i);
    req_i = 1'b0;
    sample_i = smp_en && (((cyc + 1) % 4) == 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; smp_en = 0; sample_i = 1'b0; req_i = 1'b0; cfg_we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic write_cfg(input int mw, input int iv, input bit inv);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_max_width_i = 8'(mw); cfg_interval_i = 8'(iv); cfg_invert_i = inv;
    sample_i = 1'b0; req_i = 1'b0;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic enable_samples();
    @(negedge clk_i);
    smp_en = 1;
    p0 = ((cyc + 1 + 3) / 4) * 4;
    sample_i = (((cyc + 1) % 4) == 0);
    req_i = 1'b0;
  endtask

  // requests at posedges ra/rb/rc (0 = none); records edges of the active level
  task automatic run_window(input int ra, input int rb, input int rc, input int nsteps);
    bit prev = 0;
    bit act;
    nrise = 0; nfall = 0;
    for (int i = 0; i < 4; i++) begin rise_c[i] = -1; fall_c[i] = -1; end
    for (int i = 0; i < nsteps; i++) begin
      @(negedge clk_i);
      act = (pulse_o === act_lvl);
      if (act && !prev) begin if (nrise < 4) rise_c[nrise] = cyc; nrise++; end
      if (!act && prev) begin if (nfall < 4) fall_c[nfall] = cyc; nfall++; end
      prev = act;
      req_i = ((cyc + 1) == ra) || ((cyc + 1) == rb) || ((cyc + 1) == rc);
      sample_i = smp_en && (((cyc + 1) % 4) == 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ra, rb, rc, sx, ex, e1, tt, e2;
    // R1 defaults, R9 ignored writes, R6 toggle
    do_reset();
    step();
    chk("R1 idle level after reset", pulse_o, 1);
    cfg_invert_i = 1'b1; cfg_interval_i = 8'd3; cfg_max_width_i = 8'd0;
    step(); step();
    chk("R9 cfg change without write enable ignored", pulse_o, 1);
    enable_samples();
    nv = 0; act_lvl = 1'b0;
    ra = cyc + 5; rb = cyc + 45;
    run_window(ra, rb, 0, 70);
    chk("R1 default toggle mode rise", rise_c[0], ra);
    chk("R6 toggle held across ticks until next request", fall_c[0], rb);
    chk("R6 toggle single pulse", nrise, 1);

    // R6 toggle with invert and nonzero interval
    do_reset();
    write_cfg(255, 3, 1);
    step();
    chk("R2 R9 inverted idle level", pulse_o, 0);
    enable_samples();
    nv = 3; act_lvl = 1'b1;
    ra = cyc + 6; rb = cyc + 23;
    run_window(ra, rb, 0, 50);
    chk("R6 toggle rise unpaced", rise_c[0], ra);
    chk("R6 toggle fall", fall_c[0], rb);

    // R3 R4 R5 R2 sweep
    for (int n = 0; n < 4; n++) begin
      for (int w = 0; w < 3; w++) begin
        for (int inv = 0; inv < 2; inv++) begin
          do_reset();
          write_cfg(w, n, inv[0]);
          step();
          chk($sformatf("R2 idle level n=%0d w=%0d inv=%0d", n, w, inv), pulse_o, inv == 0 ? 1 : 0);
          enable_samples();
          nv = n; act_lvl = inv[0];
          ra = p0 + 5 + n + w;
          sx = (n == 0) ? ra : first_ge(ra);
          ex = nth_after(sx, 2 * w + 1);
          run_window(ra, 0, 0, 130);
          chk($sformatf("R5 R4 start n=%0d w=%0d inv=%0d", n, w, inv), rise_c[0], sx);
          chk($sformatf("R3 end n=%0d w=%0d inv=%0d", n, w, inv), fall_c[0], ex);
          chk($sformatf("R3 one pulse n=%0d w=%0d", n, w), nrise, 1);
        end
      end
    end

    // R7 pending request, unpaced
    do_reset();
    write_cfg(1, 0, 0);
    enable_samples();
    nv = 0; act_lvl = 1'b0;
    ra = p0 + 6; rb = ra + 2;
    e1 = nth_after(ra, 3); tt = nth_after(e1, 1); e2 = nth_after(tt, 3);
    run_window(ra, rb, 0, 90);
    chk("R7 unpaced two pulses", nrise, 2);
    chk("R7 unpaced first end", fall_c[0], e1);
    chk("R7 unpaced pending start after one-tick gap", rise_c[1], tt);
    chk("R7 unpaced second end", fall_c[1], e2);

    // R7 pending request, paced
    do_reset();
    write_cfg(0, 2, 1);
    enable_samples();
    nv = 2; act_lvl = 1'b1;
    ra = first_ge(p0 + 8); rb = ra + 2;
    e1 = nth_after(ra, 1); tt = nth_after(e1, 1); e2 = nth_after(tt, 1);
    run_window(ra, rb, 0, 90);
    chk("R7 paced two pulses", nrise, 2);
    chk("R7 paced first start", rise_c[0], ra);
    chk("R7 paced pending start", rise_c[1], tt);
    chk("R7 paced second end", fall_c[1], e2);

    // R8 third request dropped
    do_reset();
    write_cfg(0, 0, 0);
    enable_samples();
    nv = 0; act_lvl = 1'b0;
    ra = p0 + 5;
    e1 = nth_after(ra, 1); tt = nth_after(e1, 1);
    run_window(ra, ra + 1, ra + 2, 100);
    chk("R8 only one pending kept", nrise, 2);
    chk("R8 pending pulse start", rise_c[1], tt);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule